// File: doc/BRIEF.md
# Register-Pair Load/Store Address Unit

This block forms data-memory addresses for the load and store instructions of a 4-bit core and carries out the memory access. An operation names a base register. That register and the one numbered after it are read in the same cycle and joined into an 8-bit base address. A signed 4-bit displacement from the instruction is added to it, and the sum wraps modulo 256. The block then drives a simple synchronous memory port. A store writes the nibble held in the data register. A load returns a nibble that is written back into the data register.

The block contains the core's 16 x 4-bit register file. It has two read ports, because the base pair needs two adjacent reads at once, and one write port. The core's other results, such as ALU writeback, reach the file through a writeback input. The block takes one operation at a time. It raises `busy` from the edge that accepts an operation until the operation has finished.

Top module: `pairaddr_lsu`

## Requirements
- R1: Register 0 always reads as zero. A write to register 0 through either the writeback input or a load return leaves it reading zero, so a store of register 0 drives `mem_wdata` = 0.
- R2: The base address has register `op_base` in bits 7:4 and register `op_base`+1 in bits 3:0.
- R3: `op_disp` is a two's-complement value from -8 (4'h8) to +7 (4'h7). It is sign extended to 8 bits and added to the base address, and the sum wraps modulo 256 in both directions.
- R4: When `op_base` is 15, the low nibble of the base comes from register 0 and is therefore zero.
- R5: A store (`op_store`=1) drives `mem_we` high for exactly one cycle, starting one clock after the accepting edge. During that cycle `mem_addr` holds the computed address and `mem_wdata` holds register `op_reg`. `mem_re` stays low during a store.
- R6: A load (`op_store`=0) drives `mem_re` high for exactly one cycle, with the same timing and addressing as a store. `mem_rdata` is taken on the clock edge that ends the following cycle and is written into register `op_reg`.
- R7: An operation is accepted on a clock edge where `op_valid`=1 and `busy`=0. After that edge `busy` is 1 for 2 cycles on a store and 3 cycles on a load. An `op_valid` seen while `busy`=1 has no effect.
- R8: While `rst` is high and after it is released, `busy`, `mem_we` and `mem_re` are 0, and `mem_addr` and `mem_wdata` are 0.
- R9: In the cycle where a load returns its data, the load write takes the register write port and a writeback request made in that cycle is dropped. At any other time, `wb_en`=1 writes `wb_data` to register `wb_sel` on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request |
| op_store | input | 1 | 1 = store, 0 = load |
| op_reg | input | 4 | Data register: store source or load destination |
| op_base | input | 4 | Register holding the high nibble of the base address |
| op_disp | input | 4 | Signed displacement |
| busy | output | 1 | An operation is in progress |
| wb_en | input | 1 | Register writeback request from the rest of the core |
| wb_sel | input | 4 | Writeback register number |
| wb_data | input | 4 | Writeback value |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 4 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read request |
| mem_rdata | input | 4 | Read data, valid the cycle after `mem_re` |

## Verification
The assertions assume that the memory answers every read request exactly one cycle later. They also assume that the requester never expects an operation to be taken while `busy` is high, and that reset is held for at least one edge before the first operation. The bench has a registered nibble-array memory with that one-cycle latency. It always waits for `busy` to fall before it issues the next operation, except in the one test that deliberately raises `op_valid` while busy to show that the request is ignored.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  // Sequencer phases of one load or store operation.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // waiting for op_valid
    ST_ADDR = 2'd1,  // address held, data register read on port A
    ST_MEM  = 2'd2,  // memory strobe on the port
    ST_LDWB = 2'd3   // load data being written back
  } lsu_state_t;
endpackage

// File: rtl/lsu_regfile.sv
// Register file with NRD combinational read ports and one write port.
// Register 0 is hardwired to zero.
module lsu_regfile #(
  parameter int REG_W = 4,
  parameter int SEL_W = 4,
  parameter int NRD   = 2,
  localparam int REG_N = 1 << SEL_W
) (
  input  logic                       clk,
  input  logic [NRD-1:0][SEL_W-1:0]  rd_sel,
  output logic [NRD-1:0][REG_W-1:0]  rd_data,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [REG_W-1:0]           wr_data
);
  logic [REG_W-1:0] cells [REG_N];

  // Writes to register 0 are dropped so that no stale value is ever stored there.
  always_ff @(posedge clk) begin
    if (wr_en && (wr_sel != '0))
      cells[wr_sel] <= wr_data;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = (rd_sel[g] == '0) ? '0 : cells[rd_sel[g]];
  end
endmodule

// File: rtl/lsu_agen.sv
// Joins the register pair into a base address and adds the sign-extended displacement.
module lsu_agen #(
  parameter int REG_W  = 4,
  parameter int DISP_W = 4,
  localparam int ADDR_W = 2 * REG_W
) (
  input  logic [REG_W-1:0]  base_hi,
  input  logic [REG_W-1:0]  base_lo,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] disp_w;

  always_comb begin
    base_w = {base_hi, base_lo};
    disp_w = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    addr   = base_w + disp_w;  // the carry out is dropped, so the sum wraps
  end
endmodule

// File: rtl/lsu_ctrl.sv
// Sequencer: accepts one operation, registers the memory strobes, returns load data.
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int SEL_W  = 4,
  localparam int ADDR_W = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic              op_store,
  input  logic [SEL_W-1:0]  op_reg,
  input  logic [ADDR_W-1:0] agen_addr,
  input  logic [REG_W-1:0]  data_rd,
  output logic              data_phase,
  output logic [SEL_W-1:0]  data_sel,
  output logic              ld_we,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REG_W-1:0]  mem_wdata,
  output logic              mem_we,
  output logic              mem_re
);
  lsu_state_t        state;
  logic              kind_q;
  logic [SEL_W-1:0]  reg_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      kind_q    <= 1'b0;
      reg_q     <= '0;
      addr_q    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (op_valid) begin
            state  <= ST_ADDR;
            kind_q <= op_store;
            reg_q  <= op_reg;
            addr_q <= agen_addr;
          end
        end
        ST_ADDR: begin
          state     <= ST_MEM;
          mem_addr  <= addr_q;
          mem_wdata <= data_rd;
          mem_we    <= kind_q;
          mem_re    <= !kind_q;
        end
        ST_MEM: begin
          mem_we <= 1'b0;
          mem_re <= 1'b0;
          state  <= kind_q ? ST_IDLE : ST_LDWB;
        end
        ST_LDWB: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign data_phase = (state == ST_ADDR);
  assign data_sel   = reg_q;
  assign ld_we      = (state == ST_LDWB);
endmodule

// File: rtl/pairaddr_lsu.sv
// Top: register-pair load/store address unit.
module pairaddr_lsu #(
  parameter int REG_W  = 4,
  parameter int SEL_W  = 4,
  parameter int DISP_W = 4,
  localparam int ADDR_W = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic              op_store,
  input  logic [SEL_W-1:0]  op_reg,
  input  logic [SEL_W-1:0]  op_base,
  input  logic [DISP_W-1:0] op_disp,
  output logic              busy,
  input  logic              wb_en,
  input  logic [SEL_W-1:0]  wb_sel,
  input  logic [REG_W-1:0]  wb_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REG_W-1:0]  mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [REG_W-1:0]  mem_rdata
);
  localparam int NRD = 2;

  logic [NRD-1:0][SEL_W-1:0] rd_sel;
  logic [NRD-1:0][REG_W-1:0] rd_data;
  logic [SEL_W-1:0]          pair_lo_sel;
  logic [ADDR_W-1:0]         agen_addr;
  logic                      data_phase;
  logic [SEL_W-1:0]          data_sel;
  logic                      ld_we;
  logic                      rf_we;
  logic [SEL_W-1:0]          rf_sel;
  logic [REG_W-1:0]          rf_data;

  // The register numbered after the base wraps modulo the file size, so 15 pairs with 0.
  assign pair_lo_sel = op_base + SEL_W'(1);

  // Port A reads the base register, or the data register in the phase after accept.
  assign rd_sel[0] = data_phase ? data_sel : op_base;
  assign rd_sel[1] = pair_lo_sel;

  // A returning load owns the write port. A writeback in the same cycle is lost.
  always_comb begin
    rf_we   = ld_we | wb_en;
    rf_sel  = ld_we ? data_sel  : wb_sel;
    rf_data = ld_we ? mem_rdata : wb_data;
  end

  lsu_regfile #(.REG_W(REG_W), .SEL_W(SEL_W), .NRD(NRD)) u_rf (
    .clk     (clk),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .wr_en   (rf_we),
    .wr_sel  (rf_sel),
    .wr_data (rf_data)
  );

  lsu_agen #(.REG_W(REG_W), .DISP_W(DISP_W)) u_agen (
    .base_hi (rd_data[0]),
    .base_lo (rd_data[1]),
    .disp    (op_disp),
    .addr    (agen_addr)
  );

  lsu_ctrl #(.REG_W(REG_W), .SEL_W(SEL_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_store   (op_store),
    .op_reg     (op_reg),
    .agen_addr  (agen_addr),
    .data_rd    (rd_data[0]),
    .data_phase (data_phase),
    .data_sel   (data_sel),
    .ld_we      (ld_we),
    .busy       (busy),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_re     (mem_re)
  );
endmodule

// File: rtl/lsu_chk.sv
// Port-level protocol checks, attached to the top by bind.
module lsu_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic              busy,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr
);
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);  // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));  // R5
  AST_RE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re);  // R6
  AST_RE_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> $stable(mem_addr));  // R6
  AST_RE_THEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> busy);  // R6
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !busy) |=> busy);  // R7
  AST_ACCEPT_STROBE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !busy) |=> ##1 (mem_we || mem_re));  // R7
  AST_STORE_DONE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !busy);  // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && !op_valid) |=> (!mem_we && !mem_re));  // R8
endmodule

bind pairaddr_lsu lsu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .busy     (busy),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .mem_addr (mem_addr)
);

// File: tb/sim_pairaddr_lsu.sv
module sim_pairaddr_lsu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0, op_store = 1'b0;
  logic [3:0] op_reg = '0, op_base = '0, op_disp = '0;
  logic       busy;
  logic       wb_en = 1'b0;
  logic [3:0] wb_sel = '0, wb_data = '0;
  logic [7:0] mem_addr;
  logic [3:0] mem_wdata, mem_rdata;
  logic       mem_we, mem_re;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  logic [3:0] mem_model [256];
  logic [3:0] ref_rf [16];

  always #10 clk = ~clk;  // 50 MHz

  pairaddr_lsu u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_store(op_store),
    .op_reg(op_reg), .op_base(op_base), .op_disp(op_disp), .busy(busy),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  // Synchronous nibble memory: read data appears the cycle after mem_re.
  initial begin
    for (int i = 0; i < 256; i++) mem_model[i] = 4'(i ^ 5);
    mem_rdata = '0;
  end
  always @(posedge clk) begin
    if (mem_we) mem_model[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem_model[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_reg(input logic [3:0] sel, input logic [3:0] val);
    @(negedge clk);
    wb_en = 1'b1; wb_sel = sel; wb_data = val;
    @(negedge clk);
    wb_en = 1'b0;
    if (sel != 0) ref_rf[sel] = val;
  endtask

  // One complete operation, checked cycle by cycle at the falling edges.
  task automatic do_op(input bit st, input logic [3:0] r, input logic [3:0] b,
                       input logic [3:0] d, input logic [7:0] exp_a,
                       input logic [3:0] exp_wd, input string req);
    logic [3:0] ld_val;
    @(negedge clk);
    op_valid = 1'b1; op_store = st; op_reg = r; op_base = b; op_disp = d;
    @(negedge clk);                       // accept edge has passed
    op_valid = 1'b0;
    chk(busy === 1'b1, "R7 busy after accept", busy, 1);
    @(negedge clk);                       // strobe cycle
    chk(mem_we === st, "R5 mem_we in strobe cycle", mem_we, st);
    chk(mem_re === !st, "R6 mem_re in strobe cycle", mem_re, !st);
    chk(mem_addr === exp_a, req, mem_addr, exp_a);
    if (st) chk(mem_wdata === exp_wd, "R5 store data", mem_wdata, exp_wd);
    ld_val = mem_model[exp_a];
    @(negedge clk);
    chk(!mem_we && !mem_re, "R5/R6 strobe one cycle", {mem_we, mem_re}, 0);
    chk(busy === !st, "R7 busy length", busy, !st);
    if (!st) begin
      @(negedge clk);
      chk(busy === 1'b0, "R7 load done", busy, 0);
      if (r != 0) ref_rf[r] = ld_val;
    end
  endtask

  // A store of register r to address 0x10 (base 15 pairs r15=1 with r0) shows its value.
  task automatic peek(input logic [3:0] r, input logic [3:0] exp_v, input string req);
    do_op(1'b1, r, 4'd15, 4'd0, 8'h10, exp_v, req);
  endtask

  // Entries: {store, data reg, base reg, disp, expected address}, with r_i = 16-i preloaded.
  localparam logic [20:0] VEC [10] = '{
    {1'b1, 4'd5,  4'd2,  4'h0, 8'hED},   // R2 plain pair
    {1'b1, 4'd0,  4'd2,  4'hF, 8'hEC},   // R1 r0 data, disp -1
    {1'b1, 4'd9,  4'd4,  4'h7, 8'hD2},   // R3 disp +7
    {1'b1, 4'd3,  4'd4,  4'h8, 8'hC3},   // R3 disp -8
    {1'b1, 4'd6,  4'd15, 4'hF, 8'h0F},   // R4 base 15
    {1'b1, 4'd7,  4'd1,  4'h3, 8'h01},   // R3 wrap upward
    {1'b0, 4'd10, 4'd2,  4'h0, 8'hED},   // R6 load
    {1'b0, 4'd0,  4'd4,  4'h7, 8'hD2},   // R1 load to r0
    {1'b0, 4'd11, 4'd0,  4'h8, 8'h07},   // R6 load, base 0, negative disp
    {1'b0, 4'd12, 4'd15, 4'hF, 8'h0F}    // R4 load
  };

  initial begin
    logic [3:0] exp_ld;
    for (int i = 0; i < 16; i++) ref_rf[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_we && !mem_re, "R8 strobes in reset", {busy, mem_we, mem_re}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_we && !mem_re, "R8 strobes after reset", {busy, mem_we, mem_re}, 0);
    chk(mem_addr === 8'h00 && mem_wdata === 4'h0, "R8 addr/data after reset",
        {mem_addr, mem_wdata}, 0);

    for (int i = 1; i < 16; i++) set_reg(4'(i), 4'(16 - i));

    for (int v = 0; v < 10; v++) begin
      logic [20:0] e;
      e = VEC[v];
      do_op(e[20], e[19:16], e[15:12], e[11:8], e[7:0], ref_rf[e[19:16]],
            (e[15:12] == 4'd15) ? "R4 address" : "R2/R3 address");
    end

    // Load results, read back through stores.
    peek(4'd10, 4'hB, "R6 loaded r10");
    peek(4'd11, 4'h2, "R6 loaded r11");
    peek(4'd12, 4'hA, "R6 loaded r12 via base 15");
    peek(4'd0,  4'h0, "R1 r0 after load");

    // R1: a writeback to r0 has no effect.
    set_reg(4'd0, 4'h9);
    peek(4'd0, 4'h0, "R1 r0 after writeback");

    // R3: base 0x00 with disp -1 wraps down to 0xFF.
    set_reg(4'd1, 4'h0);
    do_op(1'b1, 4'd5, 4'd0, 4'hF, 8'hFF, 4'hB, "R3 downward wrap");

    // R7: a request while busy is ignored.
    @(negedge clk);
    op_valid = 1'b1; op_store = 1'b1; op_reg = 4'd5; op_base = 4'd2; op_disp = 4'h0;
    @(negedge clk);
    op_store = 1'b0; op_reg = 4'd14; op_base = 4'd4;   // held while busy
    @(negedge clk);
    op_valid = 1'b0;
    chk(mem_we === 1'b1 && mem_re === 1'b0, "R7 first op only", {mem_we, mem_re}, 2);
    chk(mem_addr === 8'hED, "R7 first op address", mem_addr, 8'hED);
    @(negedge clk);
    chk(busy === 1'b0, "R7 idle after store", busy, 0);
    @(negedge clk);
    chk(!mem_we && !mem_re && !busy, "R7 no second op", {busy, mem_we, mem_re}, 0);

    // R9: the load return wins over a same-cycle writeback.
    exp_ld = mem_model[8'h10];
    @(negedge clk);
    op_valid = 1'b1; op_store = 1'b0; op_reg = 4'd13; op_base = 4'd15; op_disp = 4'h0;
    @(negedge clk);
    op_valid = 1'b0;
    @(negedge clk);
    chk(mem_re === 1'b1 && mem_addr === 8'h10, "R9 load issued", {mem_re, mem_addr}, 9'h110);
    @(negedge clk);
    wb_en = 1'b1; wb_sel = 4'd13; wb_data = 4'h6;      // same cycle as the load return
    @(negedge clk);
    wb_en = 1'b0;
    chk(busy === 1'b0, "R9 load finished", busy, 0);
    ref_rf[13] = exp_ld;
    peek(4'd13, exp_ld, "R9 load beats writeback");
    set_reg(4'd13, 4'h6);
    peek(4'd13, 4'h6, "R9 writeback when no load");

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule